// File: doc/BRIEF.md
# Big-Endian Narrow-Access Load/Store Unit

This unit sits between a processor core and a data memory that is one 32-bit word wide. For every request it forms a byte address from a base register value and a signed 16-bit displacement. It then drives one word-aligned memory access, or, when the address does not suit the access size, suppresses the access and raises an error flag.

Loads return a whole word, a halfword or a byte taken from the fetched word. Lanes are numbered in big-endian order, so the lowest byte address holds the most significant byte. Narrow loads are either sign-extended or zero-extended to 32 bits. Stores take the low byte or low halfword of the source operand, copy it onto every lane it could land in, and mark the lanes actually written with a byte-enable mask.

The memory is assumed to return read data one cycle after a read request. Load results and the error flag are therefore presented one cycle after the request.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `base_addr` plus `offset` sign-extended to 32 bits. `mem_addr` carries this address with bits 1:0 forced to zero.
- R2: Lane selection is big-endian. A byte load at address low bits k (0..3) returns memory bits [31-8k : 24-8k]. A halfword load at low bits 0 returns bits 31:16, and at low bits 2 it returns bits 15:0.
- R3: A narrow load with `req_unsigned`=0 replicates the selected field's top bit into all upper result bits.
- R4: A narrow load with `req_unsigned`=1 fills the upper result bits with zeros. A word load returns the fetched word unchanged.
- R5: A byte store (`req_size`=2'b00) at low bits k drives `mem_be` = 4'b1000 >> k, where `mem_be[3]` covers bits 31:24. It drives `mem_wdata` = `store_data[7:0]` repeated in all four lanes.
- R6: A halfword store (`req_size`=2'b01) drives `mem_be` = 4'b1100 at low bits 0 and 4'b0011 at low bits 2. It drives `mem_wdata` = `store_data[15:0]` repeated twice.
- R7: A word store (`req_size`=2'b10, with 2'b11 treated the same way) drives `mem_be` = 4'b1111 and `mem_wdata` = `store_data`.
- R8: A request is misaligned if it is a halfword access with address bit 0 set, or a word access with address bits 1:0 not zero. A misaligned request drives no `mem_req` and no write, leaves memory unchanged, raises `misalign_err` in the following cycle, and produces no `load_valid`.
- R9: An aligned load raises `load_valid` exactly one cycle after the request, with `load_data` computed from that cycle's `mem_rdata`. Stores never raise `load_valid`.
- R10: After a synchronous reset, `load_valid` and `misalign_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| store_data | input | 32 | Store source operand |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read word, one cycle after request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |
| misalign_err | output | 1 | Previous request was misaligned |

## Verification
The bench targets displacements at the sign boundary (0x8000, 0xFFFF). A design that zero-extended them would address 64 KiB too high. Byte stores into each of the four lanes are read back as a word, which exposes a little-endian lane order as a byte-reversed result. Narrow loads of fields with the top bit set, in both signed and unsigned form, catch swapped or missing extension. Misaligned word and halfword stores are followed by a load of the same word, which shows whether a design let the write through or kept `load_valid` low correctly.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int LSB_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRSV = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [LSB_W-1:0] lane;
        acc_size_e        size;
        logic             uns;
    } ld_track_t;

    function automatic logic size_misaligned(acc_size_e sz, logic [LSB_W-1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            default: return lo != '0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [LSB_W-1:0] lo);
        case (sz)
            SZ_BYTE: return LANES'(1 << (LANES - 1 - int'(lo)));
            SZ_HALF: return lo[1] ? LANES'(4'b0011) : LANES'(4'b1100);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  disp_i,
    input  acc_size_e         size_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [LSB_W-1:0]  lane_o,
    output logic              misaligned_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] byte_addr;

    assign disp_ext     = {{EXT_W{disp_i[OFF_W-1]}}, disp_i};
    assign byte_addr    = base_i + disp_ext;
    assign lane_o       = byte_addr[LSB_W-1:0];
    assign word_addr_o  = {byte_addr[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
    assign misaligned_o = size_misaligned(size_i, lane_o);

endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
    import lsu_pkg::*;
(
    input  logic              write_i,
    input  acc_size_e         size_i,
    input  logic [LSB_W-1:0]  lane_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o
);
    assign be_o = write_i ? lane_mask(size_i, lane_i) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - LANE_W * i;
        logic [LANE_W-1:0] half_pick;
        assign half_pick = (i % 2 == 0) ? src_i[2*LANE_W-1:LANE_W] : src_i[LANE_W-1:0];
        assign wdata_o[HI -: LANE_W] =
            (size_i == SZ_BYTE) ? src_i[LANE_W-1:0] :
            (size_i == SZ_HALF) ? half_pick :
                                  src_i[HI -: LANE_W];
    end

endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
    import lsu_pkg::*;
(
    input  ld_track_t         trk_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0]   shifted;
    logic [LANE_W-1:0]   byte_f;
    logic [2*LANE_W-1:0] half_f;

    assign shifted = rdata_i >> (LANE_W * (LANES - 1 - int'(trk_i.lane)));
    assign byte_f  = shifted[LANE_W-1:0];
    assign half_f  = trk_i.lane[1] ? rdata_i[2*LANE_W-1:0]
                                   : rdata_i[DATA_W-1:DATA_W-2*LANE_W];

    always_comb begin
        case (trk_i.size)
            SZ_BYTE: data_o = {{(DATA_W-LANE_W){byte_f[LANE_W-1] & ~trk_i.uns}}, byte_f};
            SZ_HALF: data_o = {{(DATA_W-2*LANE_W){half_f[2*LANE_W-1] & ~trk_i.uns}}, half_f};
            default: data_o = rdata_i;
        endcase
    end

endmodule

// File: rtl/be_lsu.sv
module be_lsu
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] store_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data,
    output logic              misalign_err
);
    acc_size_e        size_d;
    logic [LSB_W-1:0] lane_d;
    logic             bad_align;
    logic             go;
    ld_track_t        trk_q;
    ld_track_t        trk_d;

    assign size_d = acc_size_e'(req_size);

    lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
        .base_i       (base_addr),
        .disp_i       (offset),
        .size_i       (size_d),
        .word_addr_o  (mem_addr),
        .lane_o       (lane_d),
        .misaligned_o (bad_align)
    );

    assign go      = req_valid & ~bad_align;
    assign mem_req = go;
    assign mem_we  = go & req_write;

    lsu_store_path u_st (
        .write_i (mem_we),
        .size_i  (size_d),
        .lane_i  (lane_d),
        .src_i   (store_data),
        .be_o    (mem_be),
        .wdata_o (mem_wdata)
    );

    always_comb begin
        trk_d.valid = go & ~req_write;
        trk_d.err   = req_valid & bad_align;
        trk_d.lane  = lane_d;
        trk_d.size  = size_d;
        trk_d.uns   = req_unsigned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '{valid: 1'b0, err: 1'b0, lane: '0, size: SZ_WORD, uns: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    lsu_load_path u_ld (
        .trk_i   (trk_q),
        .rdata_i (mem_rdata),
        .data_o  (load_data)
    );

    assign load_valid   = trk_q.valid;
    assign misalign_err = trk_q.err;

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              req_unsigned,
    input logic [ADDR_W-1:0] base_addr,
    input logic [OFF_W-1:0]  offset,
    input logic [31:0]       store_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic [31:0]       mem_rdata,
    input logic              load_valid,
    input logic [31:0]       load_data,
    input logic              misalign_err
);
    logic [1:0] lo2;
    assign lo2 = base_addr[1:0] + offset[1:0];

    a_r8_half_odd_blocked: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_size == 2'b01 && lo2[0] |-> !mem_req && !mem_we);

    a_r8_word_odd_flag: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_size[1] && lo2 != 2'b00 |=> misalign_err && !load_valid);

    a_r8_no_both: assert property (@(posedge clk) disable iff (rst)
        !(load_valid && misalign_err));

    a_r5_byte_onehot: assert property (@(posedge clk) disable iff (rst)
        mem_we && req_size == 2'b00 |-> $onehot(mem_be));

    a_r6_half_two_lanes: assert property (@(posedge clk) disable iff (rst)
        mem_we && req_size == 2'b01 |-> $countones(mem_be) == 2);

    a_r7_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
        mem_we && req_size[1] |-> mem_be == 4'hF && mem_wdata == store_data);

    a_r1_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    a_r9_load_follows: assert property (@(posedge clk) disable iff (rst)
        mem_req && !req_write |=> load_valid);

    a_r9_store_silent: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !load_valid);

    a_r4_zero_upper: assert property (@(posedge clk) disable iff (rst)
        load_valid && $past(req_unsigned && req_size == 2'b00) |-> load_data[31:8] == 24'h0);

endmodule

bind be_lsu lsu_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/be_lsu_tb.sv
`timescale 1ns/1ps
module be_lsu_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_unsigned;
    logic [1:0]  req_size;
    logic [31:0] base_addr;
    logic [15:0] offset;
    logic [31:0] store_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        load_valid;
    logic [31:0] load_data;
    logic        misalign_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] mem    [16];
    logic [31:0] shadow [16];

    always #2.5 clk = ~clk;

    be_lsu u_dut (.*);

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sext16(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic bit is_mis(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return lo[0];
        return lo != 2'b00;
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 4'b1000 >> lo;
        if (sz == 2'b01) return lo[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_ld(logic [31:0] w, logic [1:0] sz, logic [1:0] lo, logic u);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(w >> (8 * (3 - lo)));
        h = lo[1] ? w[15:0] : w[31:16];
        if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    task automatic do_op(logic wr, logic [1:0] sz, logic u, logic [31:0] base,
                         logic [15:0] off, logic [31:0] d, output logic [31:0] got);
        logic [31:0] ea;
        logic [3:0]  be;
        logic [31:0] wd;
        bit          mis;
        int          ix;
        ea  = base + sext16(off);
        mis = is_mis(sz, ea[1:0]);
        ix  = int'(ea[5:2]);
        got = 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = u;
        base_addr = base; offset = off; store_data = d;
        #1;
        if (mis) begin
            check("R8 mem_req on misaligned", {31'h0, mem_req}, 32'h0);
        end else begin
            check("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
            if (wr) begin
                be = exp_be(sz, ea[1:0]);
                wd = exp_wd(sz, d);
                check(sz == 2'b00 ? "R5 be" : sz == 2'b01 ? "R6 be" : "R7 be", {28'h0, mem_be}, {28'h0, be});
                check(sz == 2'b00 ? "R5 wdata" : sz == 2'b01 ? "R6 wdata" : "R7 wdata", mem_wdata, wd);
                for (int k = 0; k < 4; k++)
                    if (be[k]) shadow[ix][8*k +: 8] = wd[8*k +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R8 misalign_err", {31'h0, misalign_err}, {31'h0, mis});
        check("R9 load_valid", {31'h0, load_valid}, {31'h0, (!wr && !mis)});
        if (!wr && !mis) begin
            got = load_data;
            check(sz[1] ? "R4 word load" : (u ? "R4 R2 zero-ext load" : "R3 R2 sign-ext load"),
                  load_data, exp_ld(shadow[ix], sz, ea[1:0], u));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int seed;
        seed = $urandom(32'h5EED_0017);
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 32'h8A4C_1E70 ^ (i * 32'h0103_0507);
            shadow[i] = 32'h8A4C_1E70 ^ (i * 32'h0103_0507);
        end
        req_valid = 0; req_write = 0; req_size = 0; req_unsigned = 0;
        base_addr = 0; offset = 0; store_data = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R10 reset load_valid", {31'h0, load_valid}, 32'h0);
        check("R10 reset misalign_err", {31'h0, misalign_err}, 32'h0);
        rst = 1'b0;

        // R1: word offset 32 and sign-boundary displacements
        do_op(1'b1, 2'b10, 1'b0, 32'h0000_0100, 16'd32, 32'hDEAD_BEEF, r);
        do_op(1'b0, 2'b10, 1'b0, 32'h0000_0100, 16'd32, 32'h0, r);
        check("R1 word via offset 32", r, 32'hDEAD_BEEF);
        do_op(1'b0, 2'b10, 1'b0, 32'h0001_0000, 16'h8000, 32'h0, r);
        do_op(1'b0, 2'b00, 1'b1, 32'h0000_0124, 16'hFFFF, 32'h0, r);

        // R5/R2: bytes into all four lanes, then word readback
        for (int k = 0; k < 4; k++)
            do_op(1'b1, 2'b00, 1'b0, 32'h0000_0140 + k, 16'h0, 32'hFFFF_FF10 + k, r);
        do_op(1'b0, 2'b10, 1'b0, 32'h0000_0140, 16'h0, 32'h0, r);
        check("R2 R5 big-endian byte lanes", r, 32'h1011_1213);

        // R6/R3/R4: halfword negative value, signed and unsigned
        do_op(1'b1, 2'b01, 1'b0, 32'h0000_0148, 16'h2, 32'h1234_F00D, r);
        do_op(1'b0, 2'b01, 1'b0, 32'h0000_0148, 16'h2, 32'h0, r);
        check("R3 half sign", r, 32'hFFFF_F00D);
        do_op(1'b0, 2'b01, 1'b1, 32'h0000_0148, 16'h2, 32'h0, r);
        check("R4 half zero", r, 32'h0000_F00D);
        do_op(1'b0, 2'b00, 1'b0, 32'h0000_014A, 16'h0, 32'h0, r);
        check("R3 byte sign", r, 32'hFFFF_FFF0);

        // R8: misaligned stores leave memory unchanged
        do_op(1'b1, 2'b10, 1'b0, 32'h0000_0150, 16'h1, 32'h0BAD_0BAD, r);
        do_op(1'b1, 2'b01, 1'b0, 32'h0000_0150, 16'h3, 32'h0BAD_0BAD, r);
        do_op(1'b0, 2'b10, 1'b0, 32'h0000_0150, 16'h0, 32'h0, r);
        check("R8 memory untouched", r, shadow[4'h4]);

        // R7: reserved size code behaves as word
        do_op(1'b1, 2'b11, 1'b0, 32'h0000_0160, 16'h0, 32'hCAFE_F00D, r);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] b;
            logic [15:0] o;
            b = 32'h0000_0100 + ($urandom % 64);
            o = 16'($signed($urandom % 128) - 64);
            do_op(1'($urandom), 2'($urandom % 4), 1'($urandom), b, o, $urandom, r);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule